// File: doc/BRIEF.md
# Periodic 64-bit Compare Event Unit

This unit watches a 64-bit count supplied by an external free-running counter and flags an event when that count equals a programmed 64-bit target. The target is loaded as two 32-bit halves through a simple register write port. When periodic stepping is selected, the unit adds a 32-bit step value to the target on every match. The next target is therefore always exactly one step after the previous one, and software does not have to reprogram it.

The event sets a sticky status flag, which software clears by writing 1. The interrupt line is that flag gated by an interrupt-enable bit. Every write to the target halves, the step value or the control word is confirmed by a sticky acknowledge bit. Software polls the acknowledge bits and clears them by writing 1. The counter and any interrupt routing lie outside this block. There is no data stream at this block's edge, so every pin is a plain control or status signal.

Top module: `acmp_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The registers sit at these offsets: target low half 0x200, target high half 0x204, step 0x208, control 0x240 (bit 0 arms the comparator, bit 1 selects periodic stepping), interrupt enable 0x248 (bit 0). A write becomes visible at the first clock edge after it. `reg_rdata` shows the register selected by `reg_addr` in the same cycle.
- R3: With control bit 0 set, a cycle in which `count_in` equals the target makes status bit 0 (offset 0x244) read 1 from the next cycle onward.
- R4: With control bit 0 clear, an equal count never sets the status flag and never moves the target, even when bit 1 is set. Clearing both bits stops the unit.
- R5: On a match with control bit 1 set, the target becomes target + zero-extended step at the next edge. With bit 1 clear, the target is left unchanged.
- R6: The stepped target wraps modulo 2^64.
- R7: Writing 1 to bit 0 of 0x244 clears the flag, and writing 0 leaves it. A match in the same cycle as the clear wins, so the flag stays set.
- R8: `irq` is status bit 0 AND enable bit 0, combinationally.
- R9: A write to 0x200, 0x204, 0x208 or 0x240 sets bit 0, 1, 2 or 16 of 0x24C respectively, from the next cycle onward. Writing 1 to a bit of 0x24C clears it.
- R10: A write to either target half in a match cycle takes priority over stepping. The written half takes the written data, the other half keeps its value, and the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| count_in | input | 64 | Free-running count from the external counter |
| irq | output | 1 | Compare interrupt |

## Verification
A write is visible one edge after its strobe: the register value, its acknowledge bit, and the effect of a status clear all appear then. A match cycle produces the status flag and the stepped target at the following edge, and `irq` follows the flag in the same cycle. The bench therefore holds every stimulus for exactly one cycle between falling edges. A scoreboard item is queued only on a later falling edge, with `reg_addr` driven at that edge. The monitor compares 2 ns after that edge, so each result is sampled once its register stage has settled and before the next rising edge.

// File: rtl/acmp_pkg.sv
package acmp_pkg;
  localparam int unsigned OFF_TGT_LO = 12'h200;
  localparam int unsigned OFF_TGT_HI = 12'h204;
  localparam int unsigned OFF_STEP   = 12'h208;
  localparam int unsigned OFF_CTRL   = 12'h240;
  localparam int unsigned OFF_STAT   = 12'h244;
  localparam int unsigned OFF_IEN    = 12'h248;
  localparam int unsigned OFF_ACK    = 12'h24C;

  localparam int unsigned N_ACK = 4;
  // acknowledge bit positions: target lo, target hi, step, control
  localparam int unsigned ACK_POS [N_ACK] = '{0, 1, 2, 16};

  typedef struct packed {
    logic step_mode;
    logic armed;
  } ctrl_t;
endpackage

// File: rtl/acmp_ack.sv
module acmp_ack #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [acmp_pkg::N_ACK-1:0]   wr_src,
  input  logic                         clr_wr,
  input  logic [DATA_W-1:0]            clr_mask,
  output logic [DATA_W-1:0]            ack_vec
);
  import acmp_pkg::*;

  logic [N_ACK-1:0] ack_q;

  generate
    for (genvar gi = 0; gi < N_ACK; gi++) begin : g_ack
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ack_q[gi] <= 1'b0;
        else if (wr_src[gi])
          ack_q[gi] <= 1'b1;
        else if (clr_wr && clr_mask[ACK_POS[gi]])
          ack_q[gi] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    ack_vec = '0;
    for (int k = 0; k < N_ACK; k++) ack_vec[ACK_POS[k]] = ack_q[k];
  end
endmodule

// File: rtl/acmp_target.sv
module acmp_target #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_step,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              armed,
  input  logic              step_mode,
  output logic [CNT_W-1:0]  tgt_val,
  output logic [DATA_W-1:0] step_val,
  output logic              hit
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] tgt_sum;
  logic [DATA_W-1:0] step_q;

  assign hit     = armed && (count == tgt_q);
  assign tgt_sum = tgt_q + CNT_W'(step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) tgt_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) tgt_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
    end else if (hit && step_mode) begin
      tgt_q <= tgt_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (wr_step) step_q <= wdata;
  end

  assign tgt_val  = tgt_q;
  assign step_val = step_q;
endmodule

// File: rtl/acmp_flag.sv
module acmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_req,
  input  logic ien_wr,
  input  logic ien_bit,
  output logic flag_q,
  output logic ien_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (ien_wr) ien_q <= ien_bit;
  end

  assign irq = flag_q & ien_q;
endmodule

// File: rtl/acmp_top.sv
module acmp_top #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  count_in,
  output logic              irq
);
  import acmp_pkg::*;

  logic wr_lo, wr_hi, wr_step, wr_ctrl, wr_stat, wr_ien, wr_ack;
  logic st_clr;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0]  tgt_val;
  logic [DATA_W-1:0] step_val;
  logic [DATA_W-1:0] ack_vec;
  logic hit, flag_q, ien_q;

  assign wr_lo   = reg_wr && (reg_addr == ADDR_W'(OFF_TGT_LO));
  assign wr_hi   = reg_wr && (reg_addr == ADDR_W'(OFF_TGT_HI));
  assign wr_step = reg_wr && (reg_addr == ADDR_W'(OFF_STEP));
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));
  assign wr_ien  = reg_wr && (reg_addr == ADDR_W'(OFF_IEN));
  assign wr_ack  = reg_wr && (reg_addr == ADDR_W'(OFF_ACK));
  assign st_clr  = wr_stat && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.armed     <= reg_wdata[0];
      ctrl_q.step_mode <= reg_wdata[1];
    end
  end

  acmp_target #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_target (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_step(wr_step),
    .wdata(reg_wdata), .count(count_in),
    .armed(ctrl_q.armed), .step_mode(ctrl_q.step_mode),
    .tgt_val(tgt_val), .step_val(step_val), .hit(hit)
  );

  acmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_req(st_clr),
    .ien_wr(wr_ien), .ien_bit(reg_wdata[0]),
    .flag_q(flag_q), .ien_q(ien_q), .irq(irq)
  );

  acmp_ack #(.DATA_W(DATA_W)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .wr_src({wr_ctrl, wr_step, wr_hi, wr_lo}),
    .clr_wr(wr_ack), .clr_mask(reg_wdata), .ack_vec(ack_vec)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFF_TGT_LO): reg_rdata = tgt_val[DATA_W-1:0];
      ADDR_W'(OFF_TGT_HI): reg_rdata = DATA_W'(tgt_val[CNT_W-1:DATA_W]);
      ADDR_W'(OFF_STEP):   reg_rdata = step_val;
      ADDR_W'(OFF_CTRL):   reg_rdata = DATA_W'(ctrl_q);
      ADDR_W'(OFF_STAT):   reg_rdata = DATA_W'(flag_q);
      ADDR_W'(OFF_IEN):    reg_rdata = DATA_W'(ien_q);
      ADDR_W'(OFF_ACK):    reg_rdata = ack_vec;
      default:             reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/acmp_checker.sv
module acmp_checker #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic              armed,
  input logic              step_mode,
  input logic              flag_q,
  input logic              ien_q,
  input logic              irq,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              st_clr,
  input logic [CNT_W-1:0]  tgt_val,
  input logic [DATA_W-1:0] step_val,
  input logic [DATA_W-1:0] ack_vec
);
  assert_match_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !flag_q) |=> !flag_q);

  assert_step_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && step_mode && !wr_lo && !wr_hi) |=>
      tgt_val == $past(tgt_val) + CNT_W'($past(step_val)));

  assert_tgt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !wr_lo && !wr_hi) |=> $stable(tgt_val));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && !hit) |=> !flag_q);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq);

  assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ien_q) |-> irq);

  assert_ack_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ack_vec[0]);

  assert_ack_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ack_vec[1]);
endmodule

bind acmp_top acmp_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit),
  .armed(ctrl_q.armed), .step_mode(ctrl_q.step_mode),
  .flag_q(flag_q), .ien_q(ien_q), .irq(irq),
  .wr_lo(wr_lo), .wr_hi(wr_hi), .st_clr(st_clr),
  .tgt_val(tgt_val), .step_val(step_val), .ack_vec(ack_vec)
);

// File: tb/acmp_top_tb.sv
`timescale 1ns/1ps
module acmp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] count_in = 64'h5;
  logic        irq;

  localparam logic [63:0] IDLE = 64'h5;

  always #10 clk = ~clk;

  acmp_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_in(count_in), .irq(irq)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    q_irq[$];
  logic [31:0] q_exp[$];
  string q_tag[$];

  // monitor: pops one expected item per cycle, compares after settling
  always @(negedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      automatic bit is_irq = q_irq.pop_front();
      automatic logic [31:0] e = q_exp.pop_front();
      automatic string t = q_tag.pop_front();
      automatic logic [31:0] a = is_irq ? 32'(irq) : reg_rdata;
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic chk(input logic [11:0] ad, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = ad;
    q_irq.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic chk_irq(input bit e, input string t);
    @(negedge clk);
    q_irq.push_back(1'b1); q_exp.push_back(32'(e)); q_tag.push_back(t);
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_cnt(input logic [63:0] v);
    @(negedge clk);
    count_in = v;
    @(negedge clk);
    count_in = IDLE;
  endtask

  task automatic wr_and_cnt(input logic [11:0] ad, input logic [31:0] d, input logic [63:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d; count_in = v;
    @(negedge clk);
    reg_wr = 1'b0; count_in = IDLE;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(12'h200, 0, "R1 tgt lo"); chk(12'h204, 0, "R1 tgt hi");
    chk(12'h208, 0, "R1 step");   chk(12'h240, 0, "R1 ctrl");
    chk(12'h244, 0, "R1 stat");   chk(12'h248, 0, "R1 ien");
    chk(12'h24C, 0, "R1 ack");    chk_irq(0, "R1 irq");
    // R2 / R9
    wr(12'h200, 32'h1000);
    chk(12'h200, 32'h1000, "R2 tgt lo readback");
    chk(12'h24C, 32'h1, "R9 ack lo");
    wr(12'h24C, 32'h1);
    chk(12'h24C, 32'h0, "R9 ack clear");
    wr(12'h204, 32'h2); wr(12'h208, 32'h40); wr(12'h248, 32'h1);
    chk(12'h204, 32'h2, "R2 tgt hi readback");
    chk(12'h208, 32'h40, "R2 step readback");
    chk(12'h24C, 32'h6, "R9 ack hi and step");
    wr(12'h24C, 32'hFFFF_FFFF);
    chk(12'h24C, 32'h0, "R9 ack clear all");
    // R4 disarmed with stepping selected
    wr(12'h240, 32'h2);
    chk(12'h240, 32'h2, "R2 ctrl readback");
    chk(12'h24C, 32'h1_0000, "R9 ack ctrl");
    pulse_cnt(64'h2_0000_1000);
    chk(12'h244, 0, "R4 no flag when disarmed");
    chk(12'h200, 32'h1000, "R4 target unmoved");
    // R3 / R5 / R8
    wr(12'h240, 32'h3);
    pulse_cnt(64'h2_0000_1000);
    chk(12'h244, 1, "R3 flag on match");
    chk_irq(1, "R8 irq with enable");
    chk(12'h200, 32'h1040, "R5 stepped lo");
    chk(12'h204, 32'h2, "R5 stepped hi");
    wr(12'h248, 0);  chk_irq(0, "R8 irq masked");
    wr(12'h248, 1);  chk_irq(1, "R8 irq unmasked");
    // R7
    wr(12'h244, 0);  chk(12'h244, 1, "R7 write 0 keeps flag");
    wr(12'h244, 1);  chk(12'h244, 0, "R7 write 1 clears");
    chk_irq(0, "R8 irq after clear");
    // R6 wrap
    wr(12'h200, 32'hFFFF_FFF0); wr(12'h204, 32'hFFFF_FFFF); wr(12'h208, 32'h20);
    pulse_cnt(64'hFFFF_FFFF_FFFF_FFF0);
    chk(12'h200, 32'h10, "R6 wrap lo");
    chk(12'h204, 32'h0, "R6 wrap hi");
    chk(12'h244, 1, "R3 flag on wrap match");
    // R7 set wins over clear
    wr(12'h244, 1);
    wr_and_cnt(12'h244, 32'h1, 64'h10);
    chk(12'h244, 1, "R7 match beats clear");
    chk(12'h200, 32'h30, "R5 stepped again");
    // R10 write beats step
    wr(12'h244, 1);
    wr_and_cnt(12'h200, 32'h500, 64'h30);
    chk(12'h200, 32'h500, "R10 written lo wins");
    chk(12'h204, 32'h0, "R10 hi unchanged");
    chk(12'h244, 1, "R10 flag still set");
    // R5 non-stepping
    wr(12'h240, 32'h1); wr(12'h244, 1);
    pulse_cnt(64'h500);
    chk(12'h244, 1, "R3 match without stepping");
    chk(12'h200, 32'h500, "R5 no step when bit1 clear");
    // R4 stop
    wr(12'h240, 32'h0); wr(12'h244, 1);
    pulse_cnt(64'h500);
    chk(12'h244, 0, "R4 stopped unit");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule